// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is a 7-bit-address I2C target that runs entirely on a fast system clock. It oversamples the open-drain SCL and SDA lines through two-flop synchronizers and detects clock edges, START and STOP from the synchronized samples. It shifts in the address byte and compares it with a programmable own address. It then receives bytes from the bus master or sends bytes to it. The pads are modelled as an input sample plus a pull-low enable for each line.

On the host side, a single byte buffer carries data in both directions. Received bytes, including the matching address byte with its R/W bit, come out on a valid/ready stream. `rx_valid` stays high while the buffer is full. The host consumes a byte by raising `rx_ready` while `rx_valid` is high. Data for transmission goes in through a second valid/ready stream. `tx_ready` is high only while the target is holding SCL low in a read transfer and the buffer is empty, so a pending received byte must be drained before a transmit byte is accepted.

The target holds SCL low so that a slow host can keep up. In a read transfer it always waits after each acknowledged byte. In a write transfer it waits only when `stretch_en` is set. A one-cycle `scl_release` pulse ends each wait.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `irq`, `overflow`, `host_nack` and `selected` are all 0.
- R2: Addressing works as follows:
  - After a START (SDA falling while SCL is high), the target samples 7 address bits MSB first, followed by the R/W bit (1 = read).
  - When the 7 bits equal `own_addr`, the target pulls SDA low during the ninth clock.
  - A STOP (SDA rising while SCL is high) clears `selected`.
- R3: With a mismatched address, the target never pulls SDA or SCL low and stores nothing until the next START, and `irq` stays 0.
- R4: Each accepted byte (the address byte or a written data byte) appears on `rx_data` with `rx_valid`=1 and sets `irq`. The byte is acknowledged. `rx_valid` is 0 in the cycle after a cycle with `rx_valid` and `rx_ready` both high.
- R5: A byte that completes while `rx_valid`=1 sets the sticky `overflow` flag and is not acknowledged. `rx_data` keeps the earlier byte. An `ovf_clr` pulse clears `overflow`.
- R6: In a write transfer with `stretch_en`=1, the target holds SCL low after the ninth clock of every acknowledged byte until `scl_release`. With `stretch_en`=0 it never holds SCL in a write transfer.
- R7: After acknowledging a read address, the target holds SCL low until `scl_release`. During this hold, `tx_ready`=1 only while `rx_valid`=0.
- R8: Transmitted bits go out MSB first, and `sda_oe` changes only while SCL is low.
- R9: When the master acknowledges a transmitted byte (SDA low on the ninth clock), the target sets `irq` and holds SCL low again until `scl_release`.
- R10: When the master does not acknowledge a transmitted byte, the target behaves as follows:
  - it sets `host_nack`;
  - it releases SDA and SCL;
  - it ignores the bus until a STOP or START.
- R11: An `irq_clr` pulse clears `irq` when no new event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line sample |
| sda_i | input | 1 | SDA line sample |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| own_addr | input | 7 | Target address |
| stretch_en | input | 1 | Hold SCL after each received byte in write transfers |
| scl_release | input | 1 | One-cycle pulse that ends an SCL hold |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Buffer holds an unread received byte |
| rx_ready | input | 1 | Host consumes `rx_data` |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Target accepts a transmit byte |
| irq | output | 1 | Sticky event flag |
| irq_clr | input | 1 | Clears `irq` |
| overflow | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears `overflow` |
| host_nack | output | 1 | Master did not acknowledge the last transmitted byte |
| selected | output | 1 | Target is addressed in the current transfer |
| is_read | output | 1 | Current addressed transfer is a read |

## Verification
The bench runs a bus master model against the target with open-drain wiring, and the model waits whenever SCL is held low. The following transfer patterns are used, and each tells a different behaviour apart:

- A matching write with several data values separates correct shifting and acknowledge timing from byte-order and bit-count errors.
- A foreign address shows that nothing is stored or driven.
- A write with an unread buffer separates overflow refusal from silent overwrite.
- A write with stretching enabled shows, from a stalled master, that the clock is really held until release.
- A read transfer covers the data order on the wire, the transmit gating on a full buffer, the renewed hold after a master acknowledge, and the release after a master refusal.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
  } i2ct_state_e;
endpackage

// File: rtl/i2ct_sync.sv
// Multi-stage synchronizer, one chain per line; resets to the idle-high bus level.
module i2ct_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2ct_cond.sv
// Edge and bus-condition detection on synchronized samples.
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
// Byte engine: address match, receive/transmit shifting, acknowledge and SCL holding.
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stretch_en,
  input  logic              scl_release,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              overflow,
  input  logic              ovf_clr,
  output logic              host_nack,
  output logic              selected,
  output logic              is_read,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  i2ct_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr, dbuf;
  logic              full, rw, stretch, m_acked;

  assign rx_data  = dbuf;
  assign rx_valid = full;
  assign scl_oe   = stretch;
  assign tx_ready = stretch && (state == ST_TX) && !full;
  assign selected = (state != ST_IDLE) && (state != ST_ADDR) && (state != ST_IGNORE);
  assign is_read  = selected && rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sr <= '0; dbuf <= '0;
      full <= 1'b0; rw <= 1'b0; stretch <= 1'b0; m_acked <= 1'b0;
      irq <= 1'b0; overflow <= 1'b0; host_nack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (irq_clr)              irq      <= 1'b0;
      if (ovf_clr)              overflow <= 1'b0;
      if (full && rx_ready)     full     <= 1'b0;
      if (tx_valid && tx_ready) dbuf     <= tx_data;
      if (start_det) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; stretch <= 1'b0; host_nack <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0; stretch <= 1'b0;
      end else begin
        if (stretch && scl_release) begin
          stretch <= 1'b0;
          if (state == ST_TX) begin
            sr     <= dbuf;
            sda_oe <= ~dbuf[DATA_W-1];
          end
        end
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sr <= {sr[DATA_W-2:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (sr[DATA_W-1:1] != own_addr) begin
                state <= ST_IGNORE;
              end else if (full) begin
                overflow <= 1'b1; state <= ST_IGNORE;
              end else begin
                dbuf <= sr; full <= 1'b1; irq <= 1'b1; rw <= sr[0];
                sda_oe <= 1'b1; state <= ST_ADDR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0; sda_oe <= 1'b0;
              if (rw) begin
                stretch <= 1'b1; state <= ST_TX;
              end else begin
                stretch <= stretch_en; state <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sr <= {sr[DATA_W-2:0], sda_s}; cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              irq <= 1'b1; state <= ST_RX_ACK;
              if (full) begin
                overflow <= 1'b1; sda_oe <= 1'b0;
              end else begin
                dbuf <= sr; full <= 1'b1; sda_oe <= 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              stretch <= stretch_en && sda_oe;
              sda_oe <= 1'b0; cnt <= '0; state <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              sda_oe <= 1'b0; state <= ST_TX_ACK;
            end else if (scl_fall && cnt != '0) begin
              sr <= sr << 1; sda_oe <= ~sr[DATA_W-2];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_acked <= ~sda_s;
            end else if (scl_fall) begin
              irq <= 1'b1; cnt <= '0;
              if (m_acked) begin
                stretch <= 1'b1; state <= ST_TX;
              end else begin
                host_nack <= 1'b1; state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the data line pull changes only while SCL is low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R6 / R7 / R9: a clock hold starts only on a low SCL and ends only on release
  a_r6_hold_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s);
  a_r7_hold_ends_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(scl_release));
  // R5: a pending byte is never overwritten
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R4: consuming empties the buffer
  a_r4_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> !rx_valid);
  // R3 / R10: an ignoring target drives nothing
  a_r3_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_oe && !scl_oe);
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stretch_en,
  input  logic              scl_release,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              overflow,
  input  logic              ovf_clr,
  output logic              host_nack,
  output logic              selected,
  output logic              is_read
);
  logic [1:0] lines_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s));

  i2ct_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2ct_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .stretch_en(stretch_en), .scl_release(scl_release),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .irq(irq), .irq_clr(irq_clr), .overflow(overflow), .ovf_clr(ovf_clr),
    .host_nack(host_nack), .selected(selected), .is_read(is_read),
    .scl_oe(scl_oe), .sda_oe(sda_oe));
endmodule

// File: tb/test_i2c_target_stretch.sv
module test_i2c_target_stretch;
  localparam int H = 16;
  localparam logic [6:0] ADDR = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic stretch_en = 1'b0, scl_release = 1'b0, rx_ready = 1'b0, tx_valid = 1'b0;
  logic irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic rx_valid, tx_ready, irq, overflow, host_nack, selected, is_read;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 1'b0;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_target_stretch i_i2c_target_stretch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR), .stretch_en(stretch_en),
    .scl_release(scl_release), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .irq(irq), .irq_clr(irq_clr), .overflow(overflow), .ovf_clr(ovf_clr),
    .host_nack(host_nack), .selected(selected), .is_read(is_read));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---- bus master model ----
  task automatic scl_up;
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    tick(H);
  endtask

  task automatic bit_out(input logic b);
    m_sda_low = !b;
    tick(H);
    scl_up();
    m_scl_low = 1'b1;
    tick(6);
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0;
    tick(H);
    scl_up();
    b = sda_line;
    m_scl_low = 1'b1;
    tick(6);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b0;
    tick(H);
    scl_up();
    m_sda_low = 1'b1;
    tick(H);
    m_scl_low = 1'b1;
    tick(6);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1;
    tick(H);
    scl_up();
    m_sda_low = 1'b0;
    tick(H);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(!ack);
  endtask

  // ---- host side ----
  task automatic host_read;
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0;
  endtask
  task automatic host_release;
    scl_release = 1'b1; tick(1); scl_release = 1'b0;
  endtask
  task automatic host_push(input logic [7:0] v);
    tx_data = v; tx_valid = 1'b1; tick(1); tx_valid = 1'b0;
  endtask
  task automatic clr_irq;
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
  endtask

  // ---- scenarios ----
  task automatic t_reset;
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 overflow", overflow, 0);
    check("R1 host_nack", host_nack, 0);
    check("R1 selected", selected, 0);
  endtask

  task automatic t_write_basic;
    logic ack;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    check("R2 address ack", ack, 1);
    tick(8);
    check("R4 addr byte valid", rx_valid, 1);
    check("R4 addr byte data", rx_data, {ADDR, 1'b0});
    check("R4 irq on byte", irq, 1);
    check("R2 selected", selected, 1);
    check("R2 is_read", is_read, 0);
    check("R6 no hold when disabled", scl_oe, 0);
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0;
    check("R4 consume clears", rx_valid, 0);
    clr_irq();
    check("R11 irq cleared", irq, 0);
    put_byte(8'hA5, ack);
    check("R4 data ack", ack, 1);
    tick(8);
    check("R4 data A5", rx_data, 8'hA5);
    check("R6 no hold on data", scl_oe, 0);
    host_read();
    put_byte(8'h01, ack);
    tick(8);
    check("R4 data 01", rx_data, 8'h01);
    host_read();
    clr_irq();
    bus_stop();
    tick(8);
    check("R2 stop deselects", selected, 0);
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start();
    put_byte({7'h21, 1'b0}, ack);
    check("R3 foreign addr nack", ack, 0);
    put_byte(8'h00, ack);
    check("R3 data ignored nack", ack, 0);
    tick(8);
    check("R3 nothing stored", rx_valid, 0);
    check("R3 no irq", irq, 0);
    check("R3 not selected", selected, 0);
    bus_stop();
  endtask

  task automatic t_overflow;
    logic ack;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    check("R2 ack before overflow", ack, 1);
    put_byte(8'h77, ack);
    check("R5 overflow byte nack", ack, 0);
    tick(8);
    check("R5 overflow flag", overflow, 1);
    check("R5 data kept", rx_data, {ADDR, 1'b0});
    bus_stop();
    host_read();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
    check("R5 overflow cleared", overflow, 0);
    clr_irq();
  endtask

  task automatic t_stretch;
    logic ack;
    stretch_en = 1'b1;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    tick(8);
    check("R6 hold after address", scl_oe, 1);
    host_read();
    done_flag = 1'b0;
    fork
      begin put_byte(8'h99, ack); done_flag = 1'b1; end
      begin
        tick(300);
        check("R6 master stalled", done_flag, 0);
        check("R6 still holding", scl_oe, 1);
        host_release();
      end
    join
    check("R6 data ack", ack, 1);
    tick(8);
    check("R6 data 99", rx_data, 8'h99);
    check("R6 hold after data", scl_oe, 1);
    host_read();
    host_release();
    tick(2);
    check("R6 released", scl_oe, 0);
    bus_stop();
    stretch_en = 1'b0;
    clr_irq();
  endtask

  task automatic t_read;
    logic ack;
    logic [7:0] v;
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    check("R2 read address ack", ack, 1);
    tick(8);
    check("R7 hold after read address", scl_oe, 1);
    check("R7 tx blocked while full", tx_ready, 0);
    check("R7 is_read", is_read, 1);
    host_read();
    check("R7 tx ready when empty", tx_ready, 1);
    host_push(8'h3C);
    clr_irq();
    host_release();
    get_byte(v, 1'b1);
    check("R8 first byte MSB first", v, 8'h3C);
    tick(8);
    check("R9 hold after master ack", scl_oe, 1);
    check("R9 irq after master ack", irq, 1);
    check("R9 no nack flag", host_nack, 0);
    clr_irq();
    host_push(8'hC3);
    host_release();
    get_byte(v, 1'b0);
    check("R8 second byte", v, 8'hC3);
    tick(8);
    check("R10 nack flag", host_nack, 1);
    check("R10 sda released", sda_oe, 0);
    check("R10 scl released", scl_oe, 0);
    get_byte(v, 1'b0);
    check("R10 bus ignored", v, 8'hFF);
    bus_stop();
    tick(8);
    check("R10 stop deselects", selected, 0);
    clr_irq();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_basic();
    t_mismatch();
    t_overflow();
    t_stretch();
    t_read();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule